// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Read-Modify-Write Sequencer

This block is one general-purpose I/O port of a small controller. Each bit has an output latch that the core loads from its data bus with a write strobe. The latch controls the pad. A latch bit of 0 turns on the strong pull-down. A latch bit of 1 releases the pull-down and, unless the block is built open-drain, turns on a weak pull-up. A pin therefore works as an input only while its latch holds 1, and any external source can still pull it low.

Two read paths are brought out side by side. The pin path returns the pad levels after a two-flop synchronizer. The latch path returns the stored latch bits. Byte-wide AND, OR, XOR, increment and decrement, plus single-bit set, clear and complement, go through a small sequencer that always takes its operand from the latch path, never from the pins.

The sequencer has four states. It waits in ST_IDLE. A start request taken in ST_IDLE moves it to ST_FETCH, which snapshots the latch and then always moves to ST_CALC. ST_CALC registers the result and then always moves to ST_STORE. ST_STORE offers the result to the latch and then always returns to ST_IDLE. A plain write in the same cycle as ST_STORE wins over the write-back.

Top module: `qbp_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every latch bit is 1, no pull-down is enabled, the pin path reads all ones and the busy flag is low.
- R2: When wr_en is high at a clock edge, latch_q equals wr_data after that edge.
- R3: With the default pull-up build, pad_pd_en is the bitwise inverse of latch_q and pad_pu_en equals latch_q, so no bit ever has both pulls enabled.
- R4: With OPEN_DRAIN=1, pad_pu_en is always zero, while pad_pd_en still follows the inverse of the latch.
- R5: pin_q shows the pad_in value sampled two clock edges earlier.
- R6: A bit whose latch holds 0 reads 0 on the pin path whatever the external source does. A bit whose latch holds 1 reads the external level.
- R7: A start request taken in ST_IDLE raises rmw_busy for exactly three cycles (ST_FETCH, ST_CALC, ST_STORE). The latch takes the result at the edge that leaves ST_STORE.
- R8: The byte operations apply the operand to the latch: op code 0 is AND, 1 is OR and 2 is XOR.
- R9: Op code 3 adds one to the latch and op code 4 subtracts one, both wrapping modulo 2^WIDTH (0xFF+1=0x00, 0x00-1=0xFF).
- R10: Op codes 5, 6 and 7 set, clear and complement only the bit selected by rmw_bit (0 = LSB, 7 = MSB). All other bits are left as they were.
- R11: A read-modify-write operates on the latch contents even when the external pins read differently.
- R12: A plain write in the ST_STORE cycle takes priority over the write-back and discards the result. A start request while rmw_busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Plain write strobe |
| wr_data | input | WIDTH | Data bus value to load into the latch |
| rmw_start | input | 1 | Starts a read-modify-write operation; taken only when idle |
| rmw_op | input | 3 | Operation code (0 AND, 1 OR, 2 XOR, 3 INC, 4 DEC, 5 SET, 6 CLR, 7 CPL) |
| rmw_operand | input | WIDTH | Operand for the byte operations |
| rmw_bit | input | IDX_W | Bit index for the single-bit operations |
| pad_in | input | WIDTH | Resolved pad levels seen at the pins |
| rmw_busy | output | 1 | High while the sequencer is outside ST_IDLE |
| latch_q | output | WIDTH | Latch read path |
| pin_q | output | WIDTH | Synchronized pin read path |
| pad_pd_en | output | WIDTH | Per-bit strong pull-down enable |
| pad_pu_en | output | WIDTH | Per-bit weak pull-up enable |

## Verification
The bench builds two copies side by side from the same stimulus. One copy is the default 8-bit pull-up port. The other is the same port with OPEN_DRAIN=1. The pull-up copy gives the wired-AND pad resolution against external low drivers, which is what the pin-path, masking and latch-versus-pin cases need. The open-drain copy shows that the weak pull-up never turns on, while its latch and pull-down still match the same reference model.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_INC  = 3'd3,
        OP_DEC  = 3'd4,
        OP_BSET = 3'd5,
        OP_BCLR = 3'd6,
        OP_BCPL = 3'd7
    } rmw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CALC  = 2'd2,
        ST_STORE = 2'd3
    } rmw_state_e;

endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '1;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '1;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/qbp_latch.sv
module qbp_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wb_en,
    input  logic [WIDTH-1:0] wb_data,
    output logic [WIDTH-1:0] q
);
    // A plain write outranks the sequencer write-back.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '1;
        else if (wr_en)  q <= wr_data;
        else if (wb_en)  q <= wb_data;
    end
endmodule

// File: rtl/qbp_alu.sv
module qbp_alu
    import qbp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = 3
) (
    input  rmw_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [IDX_W-1:0] idx,
    output logic [WIDTH-1:0] y
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] mask;
    assign mask = ONE << idx;

    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_INC:  y = a + ONE;
            OP_DEC:  y = a - ONE;
            OP_BSET: y = a | mask;
            OP_BCLR: y = a & ~mask;
            OP_BCPL: y = a ^ mask;
        endcase
    end
endmodule

// File: rtl/qbp_rmw_fsm.sv
module qbp_rmw_fsm
    import qbp_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] operand,
    input  logic [IDX_W-1:0] bit_sel,
    input  logic [WIDTH-1:0] latch_val,
    output logic             busy,
    output logic             wb_en,
    output logic [WIDTH-1:0] wb_data
);
    rmw_state_e       state, state_nx;
    rmw_op_e          op_r;
    logic [WIDTH-1:0] operand_r;
    logic [IDX_W-1:0] bit_r;
    logic [WIDTH-1:0] snap_r;
    logic [WIDTH-1:0] res_r;
    logic [WIDTH-1:0] alu_y;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_CALC;
            ST_CALC:  state_nx = ST_STORE;
            ST_STORE: state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_r      <= OP_AND;
            operand_r <= '0;
            bit_r     <= '0;
            snap_r    <= '0;
            res_r     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_r      <= rmw_op_e'(op);
                        operand_r <= operand;
                        bit_r     <= bit_sel;
                    end
                end
                ST_FETCH: snap_r <= latch_val;
                ST_CALC:  res_r  <= alu_y;
                ST_STORE: ;
            endcase
        end
    end

    qbp_alu #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_alu (
        .op  (op_r),
        .a   (snap_r),
        .b   (operand_r),
        .idx (bit_r),
        .y   (alu_y)
    );

    // Outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        wb_en   = (state == ST_STORE);
        wb_data = res_r;
    end
endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
    parameter int WIDTH       = 8,
    parameter int OPEN_DRAIN  = 0,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw_start,
    input  logic [2:0]       rmw_op,
    input  logic [WIDTH-1:0] rmw_operand,
    input  logic [IDX_W-1:0] rmw_bit,
    input  logic [WIDTH-1:0] pad_in,
    output logic             rmw_busy,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] pin_q,
    output logic [WIDTH-1:0] pad_pd_en,
    output logic [WIDTH-1:0] pad_pu_en
);
    logic             wb_en;
    logic [WIDTH-1:0] wb_data;

    qbp_latch #(.WIDTH(WIDTH)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wb_en   (wb_en),
        .wb_data (wb_data),
        .q       (latch_q)
    );

    qbp_rmw_fsm #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rmw_start),
        .op        (rmw_op),
        .operand   (rmw_operand),
        .bit_sel   (rmw_bit),
        .latch_val (latch_q),
        .busy      (rmw_busy),
        .wb_en     (wb_en),
        .wb_data   (wb_data)
    );

    qbp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_q)
    );

    assign pad_pd_en = ~latch_q;

    if (OPEN_DRAIN != 0) begin : g_od
        assign pad_pu_en = '0;
    end else begin : g_pu
        assign pad_pu_en = latch_q;
    end
endmodule

// File: rtl/qbp_port_chk.sv
module qbp_port_chk #(
    parameter int WIDTH   = 8,
    parameter int OD_MODE = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             rmw_start,
    input logic             rmw_busy,
    input logic [WIDTH-1:0] latch_q,
    input logic [WIDTH-1:0] pad_pd_en,
    input logic [WIDTH-1:0] pad_pu_en
);
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (latch_q == $past(wr_data)));                          // R2

    AST_PULLS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pd_en & pad_pu_en) == '0));                                // R3

    AST_OD_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        (OD_MODE != 0) |-> (pad_pu_en == '0));                           // R4

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_start && !rmw_busy) |=> rmw_busy);                          // R7

    AST_BUSY_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_busy && $past(rmw_busy) && $past(rmw_busy, 2)) |=> !rmw_busy); // R7

    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && !$past(rmw_busy)) |-> $stable(latch_q));       // R12
endmodule

bind qbp_port qbp_port_chk #(.WIDTH(WIDTH), .OD_MODE(OPEN_DRAIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rmw_start (rmw_start),
    .rmw_busy  (rmw_busy),
    .latch_q   (latch_q),
    .pad_pd_en (pad_pd_en),
    .pad_pu_en (pad_pu_en)
);

// File: tb/qbp_port_tb.sv
`timescale 1ns/1ps
module qbp_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rmw_start = 1'b0;
    logic [2:0] rmw_op = '0;
    logic [7:0] rmw_operand = '0;
    logic [2:0] rmw_bit = '0;
    logic [7:0] ext_low = '0;   // bits pulled low by an external driver

    logic       busy_a, busy_b;
    logic [7:0] latch_a, pin_a, pd_a, pu_a, pad_a;
    logic [7:0] latch_b, pin_b, pd_b, pu_b, pad_b;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit seen_edge = 1'b0;

    always #2.5 clk = ~clk;

    // Wired-AND pad resolution; an external pull-up is assumed for open-drain.
    assign pad_a = ~pd_a & ~ext_low;
    assign pad_b = ~pd_b & ~ext_low;

    qbp_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rmw_start(rmw_start), .rmw_op(rmw_op), .rmw_operand(rmw_operand),
        .rmw_bit(rmw_bit), .pad_in(pad_a), .rmw_busy(busy_a),
        .latch_q(latch_a), .pin_q(pin_a), .pad_pd_en(pd_a), .pad_pu_en(pu_a)
    );

    qbp_port #(.OPEN_DRAIN(1)) u_dut_od (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rmw_start(rmw_start), .rmw_op(rmw_op), .rmw_operand(rmw_operand),
        .rmw_bit(rmw_bit), .pad_in(pad_b), .rmw_busy(busy_b),
        .latch_q(latch_b), .pin_q(pin_b), .pad_pd_en(pd_b), .pad_pu_en(pu_b)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_latch, m_snap, m_res, m_opd;
    logic [2:0] m_op, m_bit;
    int         m_cnt;
    logic [7:0] hist[$];

    function automatic logic [7:0] ref_op(logic [2:0] op, logic [7:0] a,
                                          logic [7:0] b, logic [2:0] k);
        int v;
        v = int'(a);
        case (op)
            3'd0: return a & b;
            3'd1: return a | b;
            3'd2: return a ^ b;
            3'd3: return 8'((v + 1) % 256);
            3'd4: return 8'((v + 255) % 256);
            3'd5: begin v = v | (1 << k);  return 8'(v); end
            3'd6: begin v = v & ~(1 << k); return 8'(v); end
            default: begin v = v ^ (1 << k); return 8'(v); end
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_latch <= 8'hFF;
            m_cnt   <= 0;
            hist.delete();
        end else begin
            hist.push_back(m_latch & ~ext_low);
            if (hist.size() > 4) void'(hist.pop_front());
            if (m_cnt == 0) begin
                if (rmw_start) begin
                    m_cnt <= 3; m_op <= rmw_op; m_opd <= rmw_operand; m_bit <= rmw_bit;
                end
            end else if (m_cnt == 3) begin
                m_snap <= m_latch; m_cnt <= 2;
            end else if (m_cnt == 2) begin
                m_res <= ref_op(m_op, m_snap, m_opd, m_bit); m_cnt <= 1;
            end else begin
                m_latch <= m_res; m_cnt <= 0;
            end
            if (wr_en) m_latch <= wr_data;   // plain write wins
        end
    end

    always @(posedge clk) seen_edge <= 1'b1;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (seen_edge) begin
            logic [7:0] exp_pin;
            exp_pin = (!rst_n || hist.size() < 2) ? 8'hFF : hist[hist.size()-2];
            chk(cur_req, latch_a, m_latch);
            chk(cur_req, {7'd0, busy_a}, {7'd0, m_cnt != 0});
            chk(cur_req, pin_a, exp_pin);
            chk("R3", pd_a, ~m_latch);
            chk("R3", pu_a, m_latch);
            chk("R4", pu_b, 8'h00);
            chk("R4", pd_b, ~m_latch);
            chk("R4", latch_b, m_latch);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(); @(negedge clk); endtask

    task automatic do_write(logic [7:0] d);
        wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
    endtask

    task automatic do_rmw(logic [2:0] op, logic [7:0] opd, logic [2:0] k);
        rmw_start = 1'b1; rmw_op = op; rmw_operand = opd; rmw_bit = k;
        tick(); rmw_start = 1'b0;
        repeat (3) tick();
    endtask

    initial begin
        repeat (3) tick();
        cur_req = "R1";
        chk("R1", latch_a, 8'hFF);
        chk("R1", pin_a, 8'hFF);
        chk("R1", {7'd0, busy_a}, 8'h00);
        rst_n = 1'b1;
        tick();
        chk("R1", latch_a, 8'hFF);

        cur_req = "R2";
        do_write(8'h55); chk("R2", latch_a, 8'h55);
        do_write(8'hA3); chk("R2", latch_a, 8'hA3);

        cur_req = "R5";
        do_write(8'hFF); ext_low = 8'h3C; repeat (3) tick();
        chk("R5", pin_a, 8'hC3);
        ext_low = 8'h00; repeat (3) tick();
        chk("R5", pin_a, 8'hFF);

        cur_req = "R6";
        do_write(8'h0F); repeat (3) tick();
        chk("R6", pin_a, 8'h0F);
        ext_low = 8'h01; repeat (3) tick();
        chk("R6", pin_a, 8'h0E);
        ext_low = 8'h00;

        cur_req = "R7";
        do_write(8'h55);
        rmw_start = 1'b1; rmw_op = 3'd2; rmw_operand = 8'hFF; tick(); rmw_start = 1'b0;
        chk("R7", {7'd0, busy_a}, 8'h01); tick();
        chk("R7", {7'd0, busy_a}, 8'h01); tick();
        chk("R7", latch_a, 8'h55);        tick();
        chk("R7", {7'd0, busy_a}, 8'h00);
        chk("R7", latch_a, 8'hAA);

        cur_req = "R8";
        do_write(8'h55);
        do_rmw(3'd0, 8'h0F, 3'd0); chk("R8", latch_a, 8'h05);
        do_rmw(3'd1, 8'hF0, 3'd0); chk("R8", latch_a, 8'hF5);
        do_rmw(3'd2, 8'hFF, 3'd0); chk("R8", latch_a, 8'h0A);

        cur_req = "R9";
        do_write(8'hFF);
        do_rmw(3'd3, 8'h00, 3'd0); chk("R9", latch_a, 8'h00);
        do_rmw(3'd4, 8'h00, 3'd0); chk("R9", latch_a, 8'hFF);
        do_rmw(3'd3, 8'h00, 3'd0); chk("R9", latch_a, 8'h00);

        cur_req = "R10";
        do_rmw(3'd5, 8'h00, 3'd7); chk("R10", latch_a, 8'h80);
        do_rmw(3'd7, 8'h00, 3'd3); chk("R10", latch_a, 8'h88);
        do_rmw(3'd6, 8'hFF, 3'd7); chk("R10", latch_a, 8'h08);
        do_rmw(3'd5, 8'h00, 3'd0); chk("R10", latch_a, 8'h09);

        cur_req = "R11";
        do_write(8'hF0); ext_low = 8'hFF; repeat (3) tick();
        chk("R11", pin_a, 8'h00);
        do_rmw(3'd1, 8'h01, 3'd0); chk("R11", latch_a, 8'hF1);
        do_rmw(3'd2, 8'h0F, 3'd0); chk("R11", latch_a, 8'hFE);
        ext_low = 8'h00;

        cur_req = "R12";
        do_write(8'h00);
        rmw_start = 1'b1; rmw_op = 3'd2; rmw_operand = 8'hFF; tick();
        rmw_op = 3'd0; rmw_operand = 8'h00; tick();   // start while busy
        rmw_start = 1'b0; tick();
        wr_en = 1'b1; wr_data = 8'h5A; tick(); wr_en = 1'b0;
        chk("R12", latch_a, 8'h5A);
        tick();
        chk("R12", latch_a, 8'h5A);
        chk("R12", {7'd0, busy_a}, 8'h00);

        repeat (4) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule